// File: doc/BRIEF.md
# Timer Interrupt Status and Routing

This block sits between a bank of timer channels and the chip's interrupt lines. Each channel reports expiry as a one-cycle pulse. Per channel, the block keeps a status bit and a small state machine that turns the pulse into one of two kinds of interrupt. A level-type expiry is held until software clears it. An edge-type expiry is a single-cycle pulse.

The block then maps every channel onto one of 2^RW output lines, selected by the channel's route field. Lines at index LOW_BASE (16) and above are active low. All other lines are active high.

A global legacy-replacement mode changes this mapping. In that mode, channel 0 is pinned to line 0 and channel 1 to line 8. The external periodic-tick (PIT) input and the real-time-clock (RTC) input, which normally pass through to those two lines, are then cut off. The PIT-enable output is lowered for as long as the mode is active.

Software sees a status vector and can clear it by writing ones to it. The enable bits, trigger type and route fields are level inputs held in configuration registers elsewhere.

Every output changes on the clock edge that samples its cause.

Each channel runs the state machine `tirq_chan`:
- States: CH_IDLE, CH_HELD and CH_PULSE.
- Transitions: FIRE_LEVEL (to CH_HELD), FIRE_EDGE (to CH_PULSE), ACK (CH_HELD to CH_IDLE on a clear), PULSE_END (CH_PULSE to CH_IDLE) and KILL (any state to CH_IDLE while the channel or the global enable is off).

The legacy machine `tirq_legacy` has two states, LG_NORMAL and LG_REPLACE, with the transitions ENTER and LEAVE.

Top module: `tirq_router`

## Requirements
- R1: After reset, all status bits are 0, lines below 16 are low, lines 16 and above are high, and pit_en_o is 1.
- R2: A level-type expiry on an enabled channel sets its status bit (bit c of sts_o for channel c) after the next edge. It asserts the line chosen by the channel's 5-bit route field (bits c*5+4..c*5 of ch_route_i), and both stay asserted until cleared.
- R3: An edge-type expiry (ch_level_i bit 0) leaves the status bit at 0 and asserts the routed line for exactly one cycle.
- R4: An sts_wr_i cycle clears each status bit whose sts_wdata_i bit is 1 and deasserts its line. Bits written as 0 are unaffected.
- R5: While a channel's enable or the global enable is 0, its status is cleared after the next edge and its expiries produce no status and no line activity.
- R6: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8 regardless of their route fields. Other channels keep their route fields.
- R7: Lines 16 and above are active low (asserted = 0). Lines below 16 are active high.
- R8: Outside legacy mode, the PIT input drives line 0 and the RTC input drives line 8, one edge late. In legacy mode neither input reaches a line, and pit_en_o is 0 (1 outside).
- R9: The RTC level is tracked during legacy mode. Leaving the mode restores line 8 to the current RTC level.
- R10: An expiry and a clear on the same channel in the same cycle leave the status bit set.
- R11: Several sources routed to one line are ORed: the line stays asserted while any of them is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy replacement mode request |
| ch_en_i | input | N | Per-channel interrupt enable |
| ch_level_i | input | N | Per-channel trigger type: 1 = level, 0 = edge |
| ch_route_i | input | N*RW | Per-channel route field, channel c at bits c*RW+RW-1..c*RW |
| expire_i | input | N | Per-channel expiry pulse |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | N | Status write data, ones clear |
| pit_i | input | 1 | Legacy periodic-tick interrupt input |
| rtc_i | input | 1 | Legacy real-time-clock interrupt input |
| sts_o | output | N | Status vector |
| irq_o | output | 2^RW | Interrupt lines, polarity per line index |
| pit_en_o | output | 1 | High when legacy mode is off |

## Verification
The bench sweeps every channel over all 32 routes in both trigger types. A polarity error above line 15, a lost hold on level interrupts, or a pulse lasting more than one cycle would each show up on a specific line.

It also targets the following corner cases and the failure each one exposes:
- A same-cycle expiry and clear: a design that lets the clear win drops a live interrupt.
- A partial status write: a design that clears unwritten bits loses another channel's interrupt.
- Two channels sharing a line: a design that lets the last writer win deasserts the line while one source is still active.
- Legacy entry and exit with the RTC input changing in between: a design that freezes the RTC level, or fails to block passthrough, shows the wrong value on line 8 or line 0.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_HELD  = 2'd1,
        CH_PULSE = 2'd2
    } ch_state_e;

    typedef enum logic {
        LG_NORMAL  = 1'b0,
        LG_REPLACE = 1'b1
    } lg_state_e;

endpackage

// File: rtl/tirq_chan.sv
module tirq_chan
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic level_i,
    input  logic ch_en_i,
    input  logic glb_en_i,
    input  logic clr_i,
    output logic sts_o,
    output logic pulse_o
);

    ch_state_e state_q;
    ch_state_e state_d;
    logic      live;

    assign live = ch_en_i && glb_en_i;

    always_comb begin
        state_d = state_q;
        if (!live) begin
            state_d = CH_IDLE;                            // KILL
        end else if (expire_i) begin
            state_d = level_i ? CH_HELD : CH_PULSE;       // FIRE_LEVEL / FIRE_EDGE
        end else begin
            unique case (state_q)
                CH_IDLE:  state_d = CH_IDLE;
                CH_HELD:  state_d = clr_i ? CH_IDLE : CH_HELD;   // ACK
                CH_PULSE: state_d = CH_IDLE;                      // PULSE_END
                default:  state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sts_o   = (state_q == CH_HELD);
        pulse_o = (state_q == CH_PULSE);
    end

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && level_i && live) |=> sts_o);  // R2
    AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(expire_i && !level_i));  // R3
    AST_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> (!sts_o && !pulse_o));  // R5
    AST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && clr_i && !expire_i) |=> !sts_o);  // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && clr_i && expire_i && level_i && live) |=> sts_o);  // R10

endmodule

// File: rtl/tirq_legacy.sv
module tirq_legacy
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic legacy_i,
    input  logic pit_i,
    input  logic rtc_i,
    output logic legacy_o,
    output logic pit_en_o,
    output logic pit_lvl_o,
    output logic rtc_lvl_o
);

    lg_state_e state_q;
    lg_state_e state_d;
    logic      pit_q;
    logic      rtc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LG_NORMAL:  if (legacy_i)  state_d = LG_REPLACE;  // ENTER
            LG_REPLACE: if (!legacy_i) state_d = LG_NORMAL;   // LEAVE
            default:    state_d = LG_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LG_NORMAL;
            pit_q   <= 1'b0;
            rtc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pit_q   <= pit_i;
            rtc_q   <= rtc_i;   // tracked in every state
        end
    end

    always_comb begin
        legacy_o  = (state_q == LG_REPLACE);
        pit_en_o  = (state_q == LG_NORMAL);
        pit_lvl_o = pit_q;
        rtc_lvl_o = rtc_q;
    end

    AST_PIT_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> !pit_en_o);  // R8
    AST_PIT_EN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_i |=> pit_en_o);  // R8

endmodule

// File: rtl/tirq_linemap.sv
module tirq_linemap #(
    parameter int N        = 4,
    parameter int RW       = 5,
    parameter int LEG0     = 0,
    parameter int LEG1     = 8,
    parameter int LOW_BASE = 16,
    localparam int NL      = 1 << RW
) (
    input  logic [N-1:0]    act_i,
    input  logic [N*RW-1:0] route_i,
    input  logic            legacy_i,
    input  logic            pit_i,
    input  logic            rtc_i,
    output logic [NL-1:0]   irq_o
);

    logic [NL-1:0] hit;

    always_comb begin
        hit = '0;
        for (int c = 0; c < N; c++) begin
            logic [RW-1:0] eff;
            eff = route_i[c*RW +: RW];
            if (legacy_i && c == 0)      eff = RW'(LEG0);
            else if (legacy_i && c == 1) eff = RW'(LEG1);
            if (act_i[c]) hit[eff] = 1'b1;
        end
        if (!legacy_i) begin
            hit[LEG0] = hit[LEG0] | pit_i;
            hit[LEG1] = hit[LEG1] | rtc_i;
        end
    end

    for (genvar l = 0; l < NL; l++) begin : g_pol
        if (l >= LOW_BASE) begin : g_low
            assign irq_o[l] = ~hit[l];
        end else begin : g_high
            assign irq_o[l] = hit[l];
        end
    end

endmodule

// File: rtl/tirq_router.sv
module tirq_router #(
    parameter int N        = 4,
    parameter int RW       = 5,
    parameter int LEG0     = 0,
    parameter int LEG1     = 8,
    parameter int LOW_BASE = 16,
    localparam int NL      = 1 << RW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glb_en_i,
    input  logic            legacy_i,
    input  logic [N-1:0]    ch_en_i,
    input  logic [N-1:0]    ch_level_i,
    input  logic [N*RW-1:0] ch_route_i,
    input  logic [N-1:0]    expire_i,
    input  logic            sts_wr_i,
    input  logic [N-1:0]    sts_wdata_i,
    input  logic            pit_i,
    input  logic            rtc_i,
    output logic [N-1:0]    sts_o,
    output logic [NL-1:0]   irq_o,
    output logic            pit_en_o
);

    localparam logic LEG0_ON = (LEG0 >= LOW_BASE) ? 1'b0 : 1'b1;

    logic [N-1:0]  sts;
    logic [N-1:0]  pulse;
    logic          legacy;
    logic          pit_lvl;
    logic          rtc_lvl;
    logic [NL-1:0] idle_mask;

    for (genvar c = 0; c < N; c++) begin : g_ch
        tirq_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .expire_i (expire_i[c]),
            .level_i  (ch_level_i[c]),
            .ch_en_i  (ch_en_i[c]),
            .glb_en_i (glb_en_i),
            .clr_i    (sts_wr_i && sts_wdata_i[c]),
            .sts_o    (sts[c]),
            .pulse_o  (pulse[c])
        );
    end

    tirq_legacy u_leg (
        .clk       (clk),
        .rst_n     (rst_n),
        .legacy_i  (legacy_i),
        .pit_i     (pit_i),
        .rtc_i     (rtc_i),
        .legacy_o  (legacy),
        .pit_en_o  (pit_en_o),
        .pit_lvl_o (pit_lvl),
        .rtc_lvl_o (rtc_lvl)
    );

    tirq_linemap #(
        .N(N), .RW(RW), .LEG0(LEG0), .LEG1(LEG1), .LOW_BASE(LOW_BASE)
    ) u_map (
        .act_i    (sts | pulse),
        .route_i  (ch_route_i),
        .legacy_i (legacy),
        .pit_i    (pit_lvl),
        .rtc_i    (rtc_lvl),
        .irq_o    (irq_o)
    );

    assign sts_o = sts;

    for (genvar l = 0; l < NL; l++) begin : g_idle
        assign idle_mask[l] = (l >= LOW_BASE);
    end

    AST_LEG0_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy && sts[0]) |-> (irq_o[LEG0] == LEG0_ON));  // R6
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts == '0 && pulse == '0 && !pit_lvl && !rtc_lvl) |-> (irq_o == idle_mask));  // R7

endmodule

// File: tb/tb_tirq_router.sv
module tb_tirq_router;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int RW = 5;
    localparam int NL = 32;
    localparam logic [NL-1:0] IDLE = 32'hFFFF_0000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            glb_en, legacy, sts_wr, pit, rtc;
    logic [N-1:0]    ch_en, ch_level, expire, sts_wdata;
    logic [N*RW-1:0] route;
    logic [N-1:0]    sts;
    logic [NL-1:0]   irq;
    logic            pit_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tirq_router dut (
        .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en), .legacy_i(legacy),
        .ch_en_i(ch_en), .ch_level_i(ch_level), .ch_route_i(route),
        .expire_i(expire), .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata),
        .pit_i(pit), .rtc_i(rtc), .sts_o(sts), .irq_o(irq), .pit_en_o(pit_en)
    );

    function automatic logic [NL-1:0] lines(input logic [NL-1:0] asserted);
        return asserted ^ IDLE;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input int c);
        expire[c] = 1'b1;
        tick();
        expire = '0;
    endtask

    task automatic clear(input logic [N-1:0] m);
        sts_wr = 1'b1;
        sts_wdata = m;
        tick();
        sts_wr = 1'b0;
        sts_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; glb_en = 0; legacy = 0; sts_wr = 0; pit = 0; rtc = 0;
        ch_en = '0; ch_level = '0; expire = '0; sts_wdata = '0; route = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R1 sts", sts, 0);
        chk("R1 irq", irq, IDLE);
        chk("R1 pit_en", pit_en, 1);
        glb_en = 1; ch_en = 4'hF; ch_level = 4'hF;

        // level sweep: all channels, all routes
        for (int c = 0; c < N; c++) begin
            for (int r = 0; r < NL; r++) begin
                route[c*RW +: RW] = RW'(r);
                fire(c);
                chk("R2 sts set", sts, 64'(1 << c));
                chk(r >= 16 ? "R7 irq level" : "R2 irq level", irq, lines(NL'(1) << r));
                tick();
                chk("R2 hold", irq, lines(NL'(1) << r));
                clear(N'(1 << c));
                chk("R4 sts clr", sts, 0);
                chk("R4 irq clr", irq, IDLE);
            end
            route[c*RW +: RW] = '0;
        end

        // edge sweep
        ch_level = '0;
        for (int c = 0; c < N; c++) begin
            for (int r = 0; r < NL; r++) begin
                route[c*RW +: RW] = RW'(r);
                fire(c);
                chk(r >= 16 ? "R7 pulse" : "R3 pulse", irq, lines(NL'(1) << r));
                chk("R3 sts", sts, 0);
                tick();
                chk("R3 pulse end", irq, IDLE);
            end
            route[c*RW +: RW] = '0;
        end
        ch_level = 4'hF;

        // shared line and partial clear
        route[0 +: RW] = 5'd3; route[2*RW +: RW] = 5'd3;
        fire(0); fire(2);
        chk("R11 both", sts, 4'b0101);
        clear(4'b0001);
        chk("R4 partial", sts, 4'b0100);
        chk("R11 still", irq, lines(32'h8));
        clear(4'b0100);
        chk("R11 idle", irq, IDLE);

        // set wins over clear
        route[1*RW +: RW] = 5'd4;
        fire(1);
        expire[1] = 1; sts_wr = 1; sts_wdata = 4'b0010;
        tick();
        expire = '0; sts_wr = 0; sts_wdata = '0;
        chk("R10 sts", sts, 4'b0010);
        chk("R10 irq", irq, lines(32'h10));
        clear(4'b0010);

        // enables
        glb_en = 0;
        expire = 4'hF; tick(); expire = '0;
        chk("R5 glb sts", sts, 0);
        chk("R5 glb irq", irq, IDLE);
        glb_en = 1;
        fire(2);
        chk("R5 pre", sts, 4'b0100);
        ch_en[2] = 0; tick();
        chk("R5 ch sts", sts, 0);
        chk("R5 ch irq", irq, IDLE);
        ch_en = 4'hF;

        // passthrough
        pit = 1; tick();
        chk("R8 pit", irq, lines(32'h1));
        rtc = 1; tick();
        chk("R8 rtc", irq, lines(32'h101));
        chk("R8 pit_en", pit_en, 1);

        // legacy mode
        legacy = 1; tick();
        chk("R8 pit_en low", pit_en, 0);
        chk("R8 blocked", irq, IDLE);
        route[0 +: RW] = 5'd5; route[1*RW +: RW] = 5'd20; route[2*RW +: RW] = 5'd0;
        fire(0);
        chk("R6 ch0", irq, lines(32'h1));
        clear(4'b0001);
        fire(1);
        chk("R6 ch1", irq, lines(32'h100));
        clear(4'b0010);
        fire(2);
        chk("R6 ch2", irq, lines(32'h1));
        clear(4'b0100);
        route[3*RW +: RW] = 5'd17;
        fire(3);
        chk("R6 ch3", irq, lines(32'h2_0000));
        clear(4'b1000);
        pit = 0; rtc = 0; tick();
        rtc = 1; tick();
        chk("R9 rtc hidden", irq, IDLE);
        legacy = 0; tick();
        chk("R9 restore", irq, lines(32'h100));
        chk("R8 pit_en back", pit_en, 1);
        rtc = 0; tick();
        chk("R9 follow", irq, IDLE);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule